// File: doc/BRIEF.md
# Windowed Configuration Stream Parser

This block reads a byte-wide configuration stream and turns it into writes to an array of configuration cells. A stream opens with a synchronising preamble byte. A control byte follows, then three jump-address bytes that this block consumes and discards, and then an inverted segment count. Each segment defines a window of consecutive cells by a start and an end address and carries one data byte per cell in that window. Cells outside every window keep their contents, so a stream can rewrite only part of the array.

A cycle begins when the start handshake input and the select input are both low. The block drives its busy output low from the control byte until it reaches its final state. After the last segment, one closing byte is examined:
- A postamble ends the cycle cleanly.
- A second preamble passes the stream on to a downstream device by pulling the chain-select output low.
- Any other byte is an error.

A verify mode compares the stream against the stored cell contents instead of writing. A write-lock bit in the control byte blocks every later cycle until reset.

Top module: `cfg_stream_parser`

## Requirements
- R1: While the block waits for the preamble, every byte other than 0xB2 is discarded. Busy stays high and no cell is written.
- R2: `busy_n` goes low once the control byte is accepted and stays low until the closing byte. It is high in the final state. The block returns to idle only when `start_n` reads high.
- R3: The three bytes after the control byte have no effect on cell contents or on the error flag.
- R4: The segment-count byte holds the bitwise inverse of the count (0xFE = one segment, 0xFC = three). 0xFF means zero segments and leads straight to the closing byte.
- R5: A segment is laid out as one ignored byte, then the start address low byte and high byte, then the end address low byte and high byte. After these come end−start+1 data bytes, written in order to cells start through end inclusive.
- R6: Cells outside every window of a stream keep their previous contents.
- R7: A window whose start exceeds its end, or whose end is not below NCELLS, drives `err_n` low. The block goes to the final state and writes no further cells.
- R8: The closing byte decides the outcome:
  - 0x4D leads to the final state with `err_n` high.
  - 0xB2 drives `chain_sel_n` low until `start_n` returns high.
  - Any other value drives `err_n` low.
- R9: If bit 4 of the control byte is set, every later cycle drives `err_n` low at its preamble and writes nothing. Only reset clears this lock.
- R10: If `verify_n` is low when a cycle starts, data bytes are compared with the cell contents and not written. The first mismatch drives `err_n` low, and it stays low until the next cycle starts.
- R11: After reset, `busy_n`, `err_n` and `chain_sel_n` are high and `cell_we` is low.
- R12: `err_n` returns high when a new cycle leaves idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_in | input | 8 | Stream byte |
| byte_vld | input | 1 | Stream byte valid strobe |
| start_n | input | 1 | Start handshake, low requests a cycle |
| sel_n | input | 1 | Device select, low enables a cycle start |
| verify_n | input | 1 | Low selects verify mode, sampled at cycle start |
| cell_rdata | input | 8 | Contents of the cell at `cell_addr` |
| cell_addr | output | $clog2(NCELLS) | Cell pointer |
| cell_wdata | output | 8 | Cell write data |
| cell_we | output | 1 | Cell write enable |
| busy_n | output | 1 | Low while a cycle is loading |
| err_n | output | 1 | Low after an error or a verify mismatch |
| chain_sel_n | output | 1 | Low to select the downstream device |

## Verification
The data path is tried with three kinds of stream:
- A single window covering the whole array, which shows that every cell is reached in order.
- Three scattered windows, including one of a single cell, which separates inclusive bounds from off-by-one variants and confirms that the cells between windows are untouched.
- A zero-segment stream, which shows that the inverted count is decoded.

Verify mode is run once with matching data and once with one wrong byte, so that comparing and writing can be told apart. The error, cascade and lock paths each get their own stream. After each of these streams, the whole cell array is compared with a model kept in the bench.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_HUNT, ST_CTRL, ST_JUMP, ST_CNT, ST_NULL,
      ST_SLO, ST_SHI, ST_ELO, ST_EHI, ST_DATA, ST_CLOSE,
      ST_FIN, ST_CASC
   } pst_e;
   localparam logic [7:0] SYNC_BYTE = 8'hB2;
   localparam logic [7:0] END_BYTE  = 8'h4D;
endpackage

// File: rtl/cfgp_segcnt.sv
module cfgp_segcnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [CNT_W-1:0] raw,
   input  logic             dec,
   output logic             last
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (ld)  cnt_q <= ~raw;
      else if (dec) cnt_q <= cnt_q - 1'b1;
   end

   assign last = (cnt_q == CNT_W'(1));

   // R4
   seg_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> cnt_q != '0);
endmodule

// File: rtl/cfgp_window.sv
module cfgp_window #(
   parameter int NCELLS = 64,
   parameter int SA_W   = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [7:0]      byte_in,
   input  logic            ld_slo,
   input  logic            ld_shi,
   input  logic            ld_elo,
   input  logic            ld_ehi,
   input  logic            adv,
   output logic [SA_W-1:0] ptr,
   output logic            at_end,
   output logic            bad_next
);
   logic [SA_W-1:0] s_q, e_q, p_q;
   logic [SA_W-1:0] end_next;

   assign end_next = {byte_in, e_q[7:0]};
   assign bad_next = (s_q > end_next) || ({1'b0, end_next} >= (SA_W+1)'(NCELLS));
   assign at_end   = (p_q == e_q);
   assign ptr      = p_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_q <= '0;
         e_q <= '0;
         p_q <= '0;
      end else begin
         if (ld_slo) s_q[7:0]      <= byte_in;
         if (ld_shi) s_q[SA_W-1:8] <= byte_in;
         if (ld_elo) e_q[7:0]      <= byte_in;
         if (ld_ehi) begin
            e_q[SA_W-1:8] <= byte_in;
            p_q           <= s_q;
         end else if (adv && !at_end) begin
            p_q <= p_q + 1'b1;
         end
      end
   end

   // R5
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !at_end && !ld_ehi) |=> p_q == SA_W'($past(p_q) + 1'b1));
   // R7
   ptr_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_ehi && !bad_next) |=> (p_q <= e_q && p_q < SA_W'(NCELLS)));
endmodule

// File: rtl/cfg_stream_parser.sv
module cfg_stream_parser #(
   parameter int NCELLS     = 64,
   parameter int LOCK_BIT   = 4,
   parameter int JUMP_BYTES = 3,
   parameter bit HAS_VERIFY = 1'b1,
   localparam int AW        = $clog2(NCELLS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [7:0]    byte_in,
   input  logic          byte_vld,
   input  logic          start_n,
   input  logic          sel_n,
   input  logic          verify_n,
   input  logic [7:0]    cell_rdata,
   output logic [AW-1:0] cell_addr,
   output logic [7:0]    cell_wdata,
   output logic          cell_we,
   output logic          busy_n,
   output logic          err_n,
   output logic          chain_sel_n
);
   import cfgp_pkg::*;

   localparam int SA_W = 16;
   localparam int JW   = (JUMP_BYTES > 1) ? $clog2(JUMP_BYTES) : 1;

   if (NCELLS < 2 || NCELLS > 32768) begin : g_bad_ncells
      $error("NCELLS out of range");
   end
   if (LOCK_BIT < 0 || LOCK_BIT > 7) begin : g_bad_lock
      $error("LOCK_BIT must select a bit of the control byte");
   end
   if (JUMP_BYTES < 1) begin : g_bad_jump
      $error("JUMP_BYTES must be at least 1");
   end

   pst_e            st_q, st_d;
   logic [JW-1:0]   jcnt_q;
   logic            lock_q, verify_q, err_q;
   logic            err_set, mismatch;
   logic            seg_last, at_end, bad_next;
   logic [SA_W-1:0] ptr;
   logic            take;

   assign take = byte_vld;

   cfgp_segcnt #(.CNT_W(8)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .ld   (st_q == ST_CNT && take),
      .raw  (byte_in),
      .dec  (st_q == ST_DATA && take && at_end),
      .last (seg_last)
   );

   cfgp_window #(.NCELLS(NCELLS), .SA_W(SA_W)) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .byte_in (byte_in),
      .ld_slo  (st_q == ST_SLO && take),
      .ld_shi  (st_q == ST_SHI && take),
      .ld_elo  (st_q == ST_ELO && take),
      .ld_ehi  (st_q == ST_EHI && take),
      .adv     (st_q == ST_DATA && take),
      .ptr     (ptr),
      .at_end  (at_end),
      .bad_next(bad_next)
   );

   if (HAS_VERIFY) begin : g_verify
      assign mismatch = (st_q == ST_DATA) && take && verify_q && (cell_rdata != byte_in);
   end else begin : g_noverify
      assign mismatch = 1'b0;
   end

   always_comb begin
      st_d    = st_q;
      err_set = 1'b0;
      unique case (st_q)
         ST_IDLE:  if (!start_n && !sel_n) st_d = ST_HUNT;
         ST_HUNT:  if (take && byte_in == SYNC_BYTE) begin
                      if (lock_q) begin
                         st_d    = ST_FIN;
                         err_set = 1'b1;
                      end else begin
                         st_d = ST_CTRL;
                      end
                   end
         ST_CTRL:  if (take) st_d = ST_JUMP;
         ST_JUMP:  if (take && jcnt_q == JW'(JUMP_BYTES-1)) st_d = ST_CNT;
         ST_CNT:   if (take) st_d = (byte_in == 8'hFF) ? ST_CLOSE : ST_NULL;
         ST_NULL:  if (take) st_d = ST_SLO;
         ST_SLO:   if (take) st_d = ST_SHI;
         ST_SHI:   if (take) st_d = ST_ELO;
         ST_ELO:   if (take) st_d = ST_EHI;
         ST_EHI:   if (take) begin
                      if (bad_next) begin
                         st_d    = ST_FIN;
                         err_set = 1'b1;
                      end else begin
                         st_d = ST_DATA;
                      end
                   end
         ST_DATA:  if (take && at_end) st_d = seg_last ? ST_CLOSE : ST_NULL;
         ST_CLOSE: if (take) begin
                      if (byte_in == END_BYTE) begin
                         st_d = ST_FIN;
                      end else if (byte_in == SYNC_BYTE) begin
                         st_d = ST_CASC;
                      end else begin
                         st_d    = ST_FIN;
                         err_set = 1'b1;
                      end
                   end
         ST_FIN:   if (start_n) st_d = ST_IDLE;
         ST_CASC:  if (start_n) st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         jcnt_q   <= '0;
         lock_q   <= 1'b0;
         verify_q <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_IDLE && st_d == ST_HUNT) begin
            err_q    <= 1'b0;
            verify_q <= HAS_VERIFY && !verify_n;
            jcnt_q   <= '0;
         end else if (err_set || mismatch) begin
            err_q <= 1'b1;
         end
         if (st_q == ST_JUMP && take) jcnt_q <= jcnt_q + 1'b1;
         if (st_q == ST_CTRL && take && byte_in[LOCK_BIT]) lock_q <= 1'b1;
      end
   end

   assign cell_addr   = ptr[AW-1:0];
   assign cell_wdata  = byte_in;
   assign cell_we     = (st_q == ST_DATA) && take && !verify_q;
   assign busy_n      = !(st_q inside {ST_JUMP, ST_CNT, ST_NULL, ST_SLO, ST_SHI,
                                       ST_ELO, ST_EHI, ST_DATA, ST_CLOSE});
   assign err_n       = !err_q;
   assign chain_sel_n = (st_q != ST_CASC);

   // R10
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!err_n && st_q != ST_IDLE) |=> !err_n);
   // R6
   we_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cell_we |-> (ptr < SA_W'(NCELLS)));
   // R9
   lock_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && st_q == ST_HUNT && take && byte_in == SYNC_BYTE) |=> (st_q == ST_FIN && !err_n));
   // R2
   busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FIN) |-> busy_n);
endmodule

// File: tb/sim_cfg_stream_parser.sv
module sim_cfg_stream_parser;
   localparam int N = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] byte_in = '0;
   logic       byte_vld = 1'b0;
   logic       start_n = 1'b1;
   logic       sel_n = 1'b1;
   logic       verify_n = 1'b1;
   logic [7:0] cell_rdata;
   logic [5:0] cell_addr;
   logic [7:0] cell_wdata;
   logic       cell_we, busy_n, err_n, chain_sel_n;

   logic [7:0] mem [N];
   logic [7:0] expv [N];
   int n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   cfg_stream_parser u0 (
      .clk(clk), .rst_n(rst_n), .byte_in(byte_in), .byte_vld(byte_vld),
      .start_n(start_n), .sel_n(sel_n), .verify_n(verify_n),
      .cell_rdata(cell_rdata), .cell_addr(cell_addr), .cell_wdata(cell_wdata),
      .cell_we(cell_we), .busy_n(busy_n), .err_n(err_n), .chain_sel_n(chain_sel_n)
   );

   assign cell_rdata = mem[cell_addr];
   always @(posedge clk) if (cell_we) mem[cell_addr] <= cell_wdata;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      byte_in  = b;
      byte_vld = 1'b1;
      @(negedge clk);
      byte_vld = 1'b0;
   endtask

   task automatic begin_cycle(input bit ver);
      @(negedge clk);
      start_n  = 1'b0;
      sel_n    = 1'b0;
      verify_n = !ver;
      @(negedge clk);
   endtask

   task automatic end_cycle();
      @(negedge clk);
      start_n  = 1'b1;
      sel_n    = 1'b1;
      verify_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic header(input logic [7:0] ctrl, input int nseg);
      send(8'hB2);
      send(ctrl);
      send(8'hAA); send(8'h55); send(8'h3C);   // R3 jump bytes
      send(~8'(nseg));                         // R4 inverted count
   endtask

   function automatic logic [7:0] dval(input int seed, input int i);
      return 8'(seed + i * 13);
   endfunction

   task automatic seg(input int s, input int e, input int seed, input bit apply);
      send(8'h00);
      send(8'(s)); send(8'(s >> 8));
      send(8'(e)); send(8'(e >> 8));
      for (int i = s; i <= e; i++) begin
         send(dval(seed, i));
         if (apply) expv[i] = dval(seed, i);
      end
   endtask

   task automatic mem_cmp(input string req);
      int bad = 0;
      for (int i = 0; i < N; i++) if (mem[i] !== expv[i]) bad++;
      chk(bad == 0, req, bad, 0);
   endtask

   initial begin
      #(20 * 200000);
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) begin mem[i] = 8'h00; expv[i] = 8'h00; end
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(busy_n == 1 && err_n == 1 && chain_sel_n == 1 && cell_we == 0, "R11", {busy_n, err_n, chain_sel_n, cell_we}, 4'b1110);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 hunt, R2 busy, R3, R5 full window
      begin_cycle(0);
      send(8'h11); send(8'h4D); send(8'h00);
      chk(busy_n == 1, "R1", busy_n, 1);
      send(8'hB2); send(8'h00);
      send(8'hAA);
      chk(busy_n == 0, "R2", busy_n, 0);
      send(8'h55); send(8'h3C); send(8'hFE);
      chk(err_n == 1, "R3", err_n, 1);
      seg(0, N - 1, 3, 1);
      chk(busy_n == 0, "R2", busy_n, 0);
      send(8'h4D);
      chk(busy_n == 1 && err_n == 1, "R8", {busy_n, err_n}, 2'b11);
      repeat (3) @(negedge clk);
      chk(busy_n == 1, "R2", busy_n, 1);
      mem_cmp("R5");
      end_cycle();

      // R6 scattered windows, single-cell window
      begin_cycle(0);
      header(8'h00, 3);
      seg(5, 7, 100, 1);
      seg(20, 20, 7, 1);
      seg(40, 45, 61, 1);
      send(8'h4D);
      chk(err_n == 1, "R6", err_n, 1);
      mem_cmp("R6");
      end_cycle();

      // R4 zero segments
      begin_cycle(0);
      header(8'h00, 0);
      chk(busy_n == 0, "R4", busy_n, 0);
      send(8'h4D);
      chk(err_n == 1 && busy_n == 1, "R4", {err_n, busy_n}, 2'b11);
      mem_cmp("R4");
      end_cycle();

      // R10 verify with matching data
      begin_cycle(1);
      header(8'h00, 2);
      seg(5, 7, 100, 0);
      seg(40, 45, 61, 0);
      send(8'h4D);
      chk(err_n == 1, "R10", err_n, 1);
      mem_cmp("R10");
      end_cycle();

      // R10 verify with mismatch
      begin_cycle(1);
      header(8'h00, 1);
      seg(5, 7, 99, 0);
      chk(err_n == 0, "R10", err_n, 0);
      send(8'h4D);
      chk(err_n == 0, "R10", err_n, 0);
      mem_cmp("R10");
      end_cycle();

      // R12 error clears on new cycle
      begin_cycle(0);
      chk(err_n == 1, "R12", err_n, 1);
      header(8'h00, 0);
      send(8'h4D);
      end_cycle();

      // R7 start greater than end
      begin_cycle(0);
      header(8'h00, 1);
      send(8'h00); send(8'd10); send(8'h00); send(8'd9); send(8'h00);
      chk(err_n == 0 && busy_n == 1, "R7", {err_n, busy_n}, 2'b01);
      send(8'h77); send(8'h77);
      mem_cmp("R7");
      end_cycle();

      // R7 end past last cell
      begin_cycle(0);
      header(8'h00, 1);
      send(8'h00); send(8'd60); send(8'h00); send(8'd64); send(8'h00);
      chk(err_n == 0, "R7", err_n, 0);
      send(8'h77);
      mem_cmp("R7");
      end_cycle();

      // R8 bad closing byte
      begin_cycle(0);
      header(8'h00, 0);
      send(8'h00);
      chk(err_n == 0 && chain_sel_n == 1, "R8", {err_n, chain_sel_n}, 2'b01);
      end_cycle();

      // R8 cascade hand-off
      begin_cycle(0);
      header(8'h00, 0);
      send(8'hB2);
      chk(chain_sel_n == 0 && err_n == 1, "R8", {chain_sel_n, err_n}, 2'b01);
      end_cycle();
      chk(chain_sel_n == 1, "R8", chain_sel_n, 1);

      // R9 lock set, this cycle still writes
      begin_cycle(0);
      header(8'h10, 1);
      seg(0, 1, 200, 1);
      send(8'h4D);
      chk(err_n == 1, "R9", err_n, 1);
      mem_cmp("R9");
      end_cycle();
      begin_cycle(0);
      header(8'h00, 1);
      chk(err_n == 0 && busy_n == 1, "R9", {err_n, busy_n}, 2'b01);
      seg(2, 3, 33, 0);
      mem_cmp("R9");
      end_cycle();
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      begin_cycle(0);
      header(8'h00, 1);
      seg(2, 3, 33, 1);
      send(8'h4D);
      chk(err_n == 1, "R9", err_n, 1);
      mem_cmp("R9");
      end_cycle();

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule